// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a clocked behavioural model of the command decoder inside a byte-wide parallel NOR flash. The host issues synchronous write strobes that carry a 19-bit address and a data byte, and read strobes that return one byte on the following cycle. Multi-cycle unlock sequences are decoded with their addresses checked. They start byte programming, sector erase, chip erase, a one-time lock of the boot sector, and an identification mode.

Storage is scaled down. Each of the eleven sectors keeps 2^SECT_BYTES_W bytes, selected by the low address bits, so every address in a sector maps onto that small window. Program and erase take a set number of clock cycles, given by parameters. While an operation is busy, every read returns a status byte in place of array data.

FSM states and transitions:
- `S_READ` moves to `S_UNL1` on AA@555.
- `S_UNL1` moves to `S_UNL2` on 55@2AA.
- `S_UNL2` moves to `S_PGM_ARM` on A0, to `S_ERS_ARM` on 80, or to `S_ID` on 90, all at 555.
- `S_PGM_ARM` moves to `S_BUSY_PGM` on any write, or back to `S_READ` when that write targets a locked boot sector.
- `S_ERS_ARM` moves to `S_ERS_UNL1` on AA@555.
- `S_ERS_UNL1` moves to `S_ERS_UNL2` on 55@2AA.
- `S_ERS_UNL2` moves to `S_BUSY_SER` on 30, to `S_BUSY_CER` on 10@555, or back to `S_READ` on 40@555, which also sets the lock.
- `S_ID` moves to `S_ID_UNL1` on AA@555.
- `S_ID_UNL1` moves to `S_ID_UNL2` on 55@2AA.
- A write of F0 in any ID state returns to `S_READ`.
- The three busy states return to `S_READ` when their timer expires.
- Any other write during an unlock step returns to `S_READ`.
- Any other write in an ID state returns to `S_ID`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array byte reads FF, the lock is clear and the block is in read mode.
- R2: Only addr[10:0] is compared against command addresses. Cycle 1 must be AA at 555, and cycle 2 must be 55 at 2AA, so AAA and any upper address bits also match.
- R3: The sequence AA, 55, A0@555 followed by a write of (a, d) leaves the byte at a equal to its old value AND d, PGM_CYC cycles after the last write.
- R4: The sequence AA, 55, 80, AA, 55 followed by 30 at any address sets every byte of that address's sector to FF after SER_CYC cycles, and leaves other sectors unchanged. The sectors are:
  - 0 is 00000-03FFF.
  - 1 is 04000-05FFF.
  - 2 is 06000-07FFF.
  - 3 is 08000-0FFFF.
  - 3+n is n*10000 to n*10000+FFFF, for n = 1..7.
  - The byte within a sector is addr[SECT_BYTES_W-1:0].
- R5: The same five cycles followed by 10@555 set all sectors to FF after CER_CYC cycles, except sector 0 while locked.
- R6: Writes received while any operation is busy are ignored, and the decoder is in read mode once the operation completes.
- R7: A write that does not match the next expected cycle returns the decoder to read mode with no change to the array.
- R8: The five erase-prefix cycles followed by 40@555 set a lock that only reset clears. While locked, a program or sector erase aimed at sector 0 is skipped and the block stays in read mode.
- R9: The sequence AA, 55, 90@555 enters identification mode. In that mode, reads at address 0, 1, 2 and 3 return 1F, 13, {0000000, lock} and 10, and any other address reads 00.
- R10: Identification mode ends on F0 written to any address, or on AA, 55, F0@555. Any other write leaves it in identification mode.
- R11: A read during a busy operation returns the status byte instead of array data:
  - bit 7 is the inverse of the programmed data's bit 7 during a program, and 0 during an erase.
  - bits 5..0 are 0.
- R12: Bit 6 of the status byte inverts on every read made while busy.
- R13: rdata updates on the cycle after rd_en, and holds its value when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to factory state |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The bench sweeps every byte of all eleven sectors after each operation, so a wrong sector boundary shows up as a neighbouring sector that gets erased or keeps stale data. It targets the following faults:
- A decoder that ignored addresses, or compared A11, would take a malformed sequence, or one using AAA or high address bits, and wrongly program or refuse.
- A chip erase that kept decoding writes would let a half-entered sequence survive and program a byte after the erase.
- A lock that did not gate the boot sector would let program or erase reach it.
- A busy read that returned array data, or a toggle bit that did not flip, would fail the status checks taken right after each start.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;
    localparam int ADDR_W   = 19;
    localparam int SECT_W   = 4;
    localparam int NUM_SECT = 11;

    localparam logic [7:0] OP_KEY1  = 8'hAA;
    localparam logic [7:0] OP_KEY2  = 8'h55;
    localparam logic [7:0] OP_PGM   = 8'hA0;
    localparam logic [7:0] OP_ERS   = 8'h80;
    localparam logic [7:0] OP_IDENT = 8'h90;
    localparam logic [7:0] OP_LEAVE = 8'hF0;
    localparam logic [7:0] OP_SECT  = 8'h30;
    localparam logic [7:0] OP_CHIP  = 8'h10;
    localparam logic [7:0] OP_LOCK  = 8'h40;

    localparam logic [10:0] LOC_A = 11'h555;
    localparam logic [10:0] LOC_B = 11'h2AA;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PGM_ARM,
        S_ERS_ARM, S_ERS_UNL1, S_ERS_UNL2,
        S_ID, S_ID_UNL1, S_ID_UNL2,
        S_BUSY_PGM, S_BUSY_SER, S_BUSY_CER
    } seq_state_t;
endpackage

// File: rtl/nor_sect_map.sv
`timescale 1ns/1ps
module nor_sect_map
    import nor_seq_pkg::*;
(
    input  logic [5:0]        addr_hi,
    output logic [SECT_W-1:0] sect
);
    always_comb begin
        if (addr_hi[5:3] != 3'd0)
            sect = 4'd3 + {1'b0, addr_hi[5:3]};
        else if (addr_hi[2])
            sect = 4'd3;
        else if (addr_hi[1:0] == 2'b11)
            sect = 4'd2;
        else if (addr_hi[1:0] == 2'b10)
            sect = 4'd1;
        else
            sect = 4'd0;
    end
endmodule

// File: rtl/nor_busy_timer.sv
`timescale 1ns/1ps
module nor_busy_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= load;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int SECT_BYTES_W = 2,
    parameter int PGM_CYC      = 6,
    parameter int SER_CYC      = 12,
    parameter int CER_CYC      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int IDX_W     = SECT_W + SECT_BYTES_W;
    localparam int MEM_DEPTH = 1 << IDX_W;
    localparam int CNT_MAX   = (CER_CYC > SER_CYC) ?
                               ((CER_CYC > PGM_CYC) ? CER_CYC : PGM_CYC) :
                               ((SER_CYC > PGM_CYC) ? SER_CYC : PGM_CYC);
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    seq_state_t        state, nstate;
    logic [7:0]        mem [MEM_DEPTH];
    logic [SECT_W-1:0] sect, ers_sect;
    logic [IDX_W-1:0]  idx, pgm_idx;
    logic [7:0]        pgm_data, id_val;
    logic              lock, lock_set, cap_pgm, cap_ers, tgl;
    logic              tmr_start, tmr_done, at_a, at_b, busy, in_id, boot_hit;
    logic [CNT_W-1:0]  tmr_load;

    nor_sect_map u_map (.addr_hi(addr[18:13]), .sect(sect));

    nor_busy_timer #(.CW(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load), .done(tmr_done)
    );

    assign idx      = {sect, addr[SECT_BYTES_W-1:0]};
    assign at_a     = (addr[10:0] == LOC_A);
    assign at_b     = (addr[10:0] == LOC_B);
    assign boot_hit = lock && (sect == '0);
    assign busy     = (state == S_BUSY_PGM) || (state == S_BUSY_SER) || (state == S_BUSY_CER);
    assign in_id    = (state == S_ID) || (state == S_ID_UNL1) || (state == S_ID_UNL2);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_READ;
        else        state <= nstate;
    end

    always_comb begin
        nstate    = state;
        tmr_start = 1'b0;
        tmr_load  = '0;
        lock_set  = 1'b0;
        cap_pgm   = 1'b0;
        cap_ers   = 1'b0;
        unique case (state)
            S_READ:     if (wr_en) nstate = (wdata == OP_KEY1 && at_a) ? S_UNL1 : S_READ;
            S_UNL1:     if (wr_en) nstate = (wdata == OP_KEY2 && at_b) ? S_UNL2 : S_READ;
            S_UNL2: if (wr_en) begin
                if (at_a && wdata == OP_PGM)        nstate = S_PGM_ARM;
                else if (at_a && wdata == OP_ERS)   nstate = S_ERS_ARM;
                else if (at_a && wdata == OP_IDENT) nstate = S_ID;
                else                                nstate = S_READ;
            end
            S_PGM_ARM: if (wr_en) begin
                if (boot_hit) nstate = S_READ;
                else begin
                    nstate    = S_BUSY_PGM;
                    tmr_start = 1'b1;
                    tmr_load  = CNT_W'(PGM_CYC);
                    cap_pgm   = 1'b1;
                end
            end
            S_ERS_ARM:  if (wr_en) nstate = (wdata == OP_KEY1 && at_a) ? S_ERS_UNL1 : S_READ;
            S_ERS_UNL1: if (wr_en) nstate = (wdata == OP_KEY2 && at_b) ? S_ERS_UNL2 : S_READ;
            S_ERS_UNL2: if (wr_en) begin
                nstate = S_READ;
                if (wdata == OP_SECT && !boot_hit) begin
                    nstate    = S_BUSY_SER;
                    tmr_start = 1'b1;
                    tmr_load  = CNT_W'(SER_CYC);
                    cap_ers   = 1'b1;
                end else if (at_a && wdata == OP_CHIP) begin
                    nstate    = S_BUSY_CER;
                    tmr_start = 1'b1;
                    tmr_load  = CNT_W'(CER_CYC);
                end else if (at_a && wdata == OP_LOCK) begin
                    lock_set  = 1'b1;
                end
            end
            S_ID: if (wr_en) begin
                if (wdata == OP_LEAVE)               nstate = S_READ;
                else if (wdata == OP_KEY1 && at_a)   nstate = S_ID_UNL1;
            end
            S_ID_UNL1: if (wr_en) begin
                if (wdata == OP_LEAVE)               nstate = S_READ;
                else if (wdata == OP_KEY2 && at_b)   nstate = S_ID_UNL2;
                else                                 nstate = S_ID;
            end
            S_ID_UNL2:  if (wr_en) nstate = (wdata == OP_LEAVE) ? S_READ : S_ID;
            S_BUSY_PGM, S_BUSY_SER, S_BUSY_CER: if (tmr_done) nstate = S_READ;
            default:    nstate = S_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
            lock     <= 1'b0;
            pgm_idx  <= '0;
            pgm_data <= '0;
            ers_sect <= '0;
        end else begin
            if (lock_set) lock <= 1'b1;
            if (cap_pgm) begin
                pgm_idx  <= idx;
                pgm_data <= wdata;
            end
            if (cap_ers) ers_sect <= sect;
            if (tmr_done && state == S_BUSY_PGM)
                mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
            if (tmr_done && state == S_BUSY_SER)
                for (int i = 0; i < MEM_DEPTH; i++)
                    if (SECT_W'(i >> SECT_BYTES_W) == ers_sect) mem[i] <= 8'hFF;
            if (tmr_done && state == S_BUSY_CER)
                for (int i = 0; i < MEM_DEPTH; i++)
                    if ((i >> SECT_BYTES_W) != 0 || !lock) mem[i] <= 8'hFF;
        end
    end

    always_comb begin
        unique case (addr)
            19'd0:   id_val = 8'h1F;
            19'd1:   id_val = 8'h13;
            19'd2:   id_val = {7'd0, lock};
            19'd3:   id_val = 8'h10;
            default: id_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tgl   <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= {(state == S_BUSY_PGM) ? ~pgm_data[7] : 1'b0, tgl, 6'd0};
                tgl   <= ~tgl;
            end else if (in_id) begin
                rdata <= id_val;
            end else begin
                rdata <= mem[idx];
            end
        end
    end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
`timescale 1ns/1ps
module nor_cmd_seq_chk
    import nor_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input seq_state_t state,
    input logic       lock
);
    logic bsy;
    assign bsy = (state == S_BUSY_PGM) || (state == S_BUSY_SER) || (state == S_BUSY_CER);

    // R11
    erase_status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (state == S_BUSY_SER || state == S_BUSY_CER)) |=> (rdata[7] == 1'b0 && rdata[5] == 1'b0));

    // R12
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bsy && $past(rd_en && bsy)) |=> (rdata[6] != $past(rdata[6])));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R6
    chip_erase_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY_CER && wr_en) |=> (state == S_BUSY_CER || state == S_READ));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .state(state), .lock(lock)
);

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
    localparam int SBW = 2, PGM = 6, SER = 12, CER = 20;
    localparam int NB  = 1 << SBW;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, rd_en;
    logic [18:0] addr;
    logic [7:0]  wdata, rdata, r1, r2;
    logic [7:0]  exp_mem [11*NB];
    bit          locked;
    int          n_chk, n_fail;

    always #5 clk = ~clk;

    nor_cmd_seq #(.SECT_BYTES_W(SBW), .PGM_CYC(PGM), .SER_CYC(SER), .CER_CYC(CER)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic int sect_of(input logic [18:0] a);
        if (a < 19'h04000) return 0;
        if (a < 19'h06000) return 1;
        if (a < 19'h08000) return 2;
        if (a < 19'h10000) return 3;
        return 3 + int'(a) / 'h10000;
    endfunction

    function automatic logic [18:0] base_of(input int s);
        case (s)
            0: return 19'h00000;
            1: return 19'h04000;
            2: return 19'h06000;
            3: return 19'h08000;
            default: return 19'((s - 3) * 'h10000);
        endcase
    endfunction

    function automatic int idx_of(input logic [18:0] a);
        return sect_of(a) * NB + int'(a) % NB;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic verify_all(input string tag);
        logic [7:0] v;
        for (int s = 0; s < 11; s++)
            for (int b = 0; b < NB; b++) begin
                rd(base_of(s) + 19'(b), v);
                chk(tag, v, exp_mem[s*NB+b]);
            end
    endtask

    task automatic pgm(input logic [18:0] a, input logic [7:0] d);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(a, d);
        if (!(locked && sect_of(a) == 0)) exp_mem[idx_of(a)] &= d;
        idle(PGM + 2);
    endtask

    task automatic ers_prefix();
        wr(19'h555, 8'hAA); wr(19'hAAA, 8'h55); wr(19'h555, 8'h80);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [18:0] t;
        n_chk = 0; n_fail = 0; locked = 0;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < 11*NB; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state over every byte
        verify_all("R1");

        // R9 identification reads
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h90);
        rd(19'd0, v); chk("R9 id0", v, 8'h1F);
        rd(19'd1, v); chk("R9 id1", v, 8'h13);
        rd(19'd2, v); chk("R9 id2", v, 8'h00);
        rd(19'd3, v); chk("R9 id3", v, 8'h10);
        rd(19'd4, v); chk("R9 id4", v, 8'h00);
        // R10 stray write keeps ID mode, single F0 leaves it
        wr(19'h345, 8'h12);
        rd(19'd1, v); chk("R10 stay", v, 8'h13);
        wr(19'h6789A, 8'hF0);
        rd(19'd0, v); chk("R10 exit1", v, 8'hFF);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h90);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hF0);
        rd(19'd0, v); chk("R10 exit3", v, 8'hFF);

        // R3 R11 R12 status during program
        t = 19'h50002;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(t, 8'h3C);
        rd(t, r1); rd(t, r2);
        chk("R11 pgm bit7", {7'd0, r1[7]}, 8'h01);
        chk("R11 low bits", {2'd0, r1[5:0]}, 8'h00);
        chk("R12 toggle", {7'd0, r1[6] ^ r2[6]}, 8'h01);
        exp_mem[idx_of(t)] &= 8'h3C;
        idle(PGM + 2);
        rd(t, v); chk("R3 first", v, 8'h3C);

        // R3 program a byte in every sector
        for (int s = 0; s < 11; s++)
            pgm(base_of(s) + 19'(s % NB) + 19'h100, 8'hA5 ^ 8'(s * 17));
        verify_all("R3 sweep");
        t = base_of(4) + 19'd1;
        pgm(t, 8'h0F);
        rd(t, v); chk("R3 and", v, exp_mem[idx_of(t)]);

        // R2 address aliasing: high bits and A11 ignored
        t = 19'h30003;
        wr(19'h7F555, 8'hAA); wr(19'h00AAA, 8'h55); wr(19'h1B555, 8'hA0); wr(t, 8'h81);
        exp_mem[idx_of(t)] &= 8'h81;
        idle(PGM + 2);
        rd(t, v); chk("R2 alias", v, exp_mem[idx_of(t)]);

        // R7 malformed sequences leave the array alone
        t = 19'h20001;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h56); wr(19'h555, 8'hA0); wr(t, 8'h00);
        idle(PGM + 2);
        rd(t, v); chk("R7 bad data", v, exp_mem[idx_of(t)]);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h554, 8'hA0); wr(t, 8'h00);
        idle(PGM + 2);
        rd(t, v); chk("R7 bad addr", v, exp_mem[idx_of(t)]);
        ers_prefix(); wr(t, 8'h20);
        idle(SER + 2);
        verify_all("R7 bad erase");

        // R4 sector erase with status
        t = 19'h0C123;
        ers_prefix(); wr(t, 8'h30);
        rd(t, v); chk("R11 erase bit7", {7'd0, v[7]}, 8'h00);
        for (int b = 0; b < NB; b++) exp_mem[3*NB+b] = 8'hFF;
        idle(SER + 2);
        verify_all("R4 sect3");
        ers_prefix(); wr(19'h7ABCD, 8'h30);
        for (int b = 0; b < NB; b++) exp_mem[10*NB+b] = 8'hFF;
        idle(SER + 2);
        verify_all("R4 sect10");

        // R8 lockout
        ers_prefix(); wr(19'h555, 8'h40);
        locked = 1;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h90);
        rd(19'd2, v); chk("R8 lock id", v, 8'h01);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hF0);
        t = 19'h00101;
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(t, 8'h00);
        rd(t, v); chk("R8 pgm skipped", v, exp_mem[idx_of(t)]);
        idle(PGM + 2);
        ers_prefix(); wr(19'h01000, 8'h30);
        idle(SER + 2);
        verify_all("R8 boot kept");

        // R5 R6 chip erase, writes during it ignored
        ers_prefix(); wr(19'h555, 8'h10);
        rd(19'h40000, v); chk("R11 chip bit7", {7'd0, v[7]}, 8'h00);
        wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
        idle(CER + 2);
        t = 19'h60002;
        wr(19'h555, 8'hA0); wr(t, 8'h00);
        idle(PGM + 2);
        for (int i = NB; i < 11*NB; i++) exp_mem[i] = 8'hFF;
        rd(t, v); chk("R6 ignored", v, 8'hFF);
        verify_all("R5 chip");

        summary();
        $finish;
    end
endmodule